// File: doc/BRIEF.md
# Mode-Dependent Host Control Register

This block is a 32-bit control register that an external host reads and writes over one of two bus styles. A two-bit mode input picks the style. In the PCI-style mode the full 32-bit word moves on every access, and the register sits at a fixed offset of 0x010 above a programmable memory-space base. In the universal-bus mode the register is found by matching the base-address bits of the address and a fixed register index. The data path in that mode is 24 or 16 bits wide. The width is chosen by the transmit-format and receive-format fields that the register itself holds.

Host writes land in a pending (shadow) copy and honour the per-byte enables. The pending copy moves into the active register only when the host signals that the transaction has completed. The active register drives the control outputs that the rest of the interface uses, and it is also what a read returns. Reserved bits never hold a one.

Top module: `hostCtrlReg`

## Requirements
- R1: During reset and right after it, `ctrlOut` is all zeros and `rdData` is zero.
- R2: With `busMode` = 1, the register is selected only when `memSpace` is high and `addr` equals `pciBase` + 0x010. Any other address, or `memSpace` low, leaves reads at zero and writes without effect.
- R3: In PCI-style mode a selected read returns all 32 active bits, and a selected write can load all four byte lanes.
- R4: With `busMode` = 2 or 3, the register is selected only when `addr[10:3]` equals `ubBase` and `addr[2:0]` equals 4.
- R5: In universal-bus mode, if the active transmit-format field (bits 9:8) or the active receive-format field (bits 11:10) is zero, the access is 24 bits wide. A read returns active bits 23:0 with bits 31:24 at zero. A write may update only lanes 0 to 2, and lane 3 keeps its value.
- R6: In universal-bus mode, if both format fields are nonzero, the access is 16 bits wide. A read returns active bits 15:0 with bits 31:16 at zero. A write updates only lanes 0 and 1 and clears pending bits 31:16.
- R7: `byteEn[i]` gates byte lane i, which is bits 8i+7 to 8i. A lane whose enable is low keeps its previous pending value.
- R8: Writes change only the pending copy. When `commit` is high at a clock edge, the active register takes the pending value as it stood before that edge. Without `commit`, `ctrlOut` does not change.
- R9: Only these bits are writable: 0 (transmit request enable), 1 (receive request enable), 4:2 (host flags), 5 (DMA enable), 9:8 (transmit format), 11:10 (receive format), 14:12 (semaphores), 18 (extra semaphore) and 24 (upper option). All other bits of `ctrlOut` and of read data are always zero.
- R10: With `busMode` = 0, no access is selected: reads return zero and writes do nothing.

Port `commit` strobes the transfer from the pending copy to the active register, as described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busMode | input | 2 | 1 = PCI-style 32-bit, 2/3 = universal bus, 0 = blocked |
| memSpace | input | 1 | Current PCI-style access targets memory space |
| addr | input | 32 | Access address |
| pciBase | input | 32 | Memory-space base address for PCI-style mode |
| ubBase | input | 8 | Base match value for addr[10:3] in universal-bus mode |
| wrEn | input | 1 | Write access this cycle |
| rdEn | input | 1 | Read access this cycle |
| byteEn | input | 4 | Per-lane write enables |
| wrData | input | 32 | Write data, right-aligned for narrow modes |
| commit | input | 1 | Transaction complete: copy pending into active |
| rdData | output | 32 | Read data, zero when not selected |
| ctrlOut | output | 32 | Active register contents driving the controlled logic |

## Verification
Some properties are checked on every cycle. Reserved bits of `ctrlOut` stay zero. `ctrlOut` only moves after a commit. A blocked mode returns zero read data. Universal-bus reads never carry the top byte, and carry no upper half in the narrow format.

Other behaviour is shown only by the bench scenarios, which compare against a behavioural model: the exact address decode in both modes, byte-lane merging, the 16-bit zero-fill, and the automatic switch between widths once a committed write changes the format fields.

// File: rtl/hctlPkg.sv
package hctlPkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam logic [DATA_W-1:0] WR_MASK = 32'h0104_7F3F;
  localparam int TXFMT_LSB = 8;
  localparam int RXFMT_LSB = 10;

  typedef enum logic [1:0] {W_NONE = 2'd0, W_16 = 2'd1, W_24 = 2'd2, W_32 = 2'd3} accWidth_t;

  typedef struct packed {
    logic             hit;
    accWidth_t        width;
    logic [LANES-1:0] wrLane;
    logic             clrHigh;
    logic             commit;
  } strobes_t;
endpackage

// File: rtl/hctlControl.sv
module hctlControl
  import hctlPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UB_BASE_W  = 8,
  parameter int PCI_OFFSET = 'h010
) (
  input  logic [1:0]           busMode,
  input  logic                 memSpace,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    pciBase,
  input  logic [UB_BASE_W-1:0] ubBase,
  input  logic                 wrEn,
  input  logic [LANES-1:0]     byteEn,
  input  logic                 commit,
  input  logic [1:0]           txFmt,
  input  logic [1:0]           rxFmt,
  output strobes_t             stb
);
  localparam int UB_IDX_W = 3;
  localparam logic [UB_IDX_W-1:0] UB_IDX = 3'd4;
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(PCI_OFFSET);

  logic pciHit, ubHit, narrow;

  assign pciHit = (busMode == 2'd1) && memSpace && (addr == pciBase + OFFS);
  assign ubHit  = busMode[1] &&
                  (addr[UB_BASE_W+UB_IDX_W-1:UB_IDX_W] == ubBase) &&
                  (addr[UB_IDX_W-1:0] == UB_IDX);
  assign narrow = (txFmt != 2'd0) && (rxFmt != 2'd0);

  always_comb begin
    stb         = '0;
    stb.commit  = commit;
    stb.hit     = pciHit || ubHit;
    if (pciHit)      stb.width = W_32;
    else if (ubHit)  stb.width = narrow ? W_16 : W_24;
    else             stb.width = W_NONE;

    if (wrEn) begin
      unique case (stb.width)
        W_32: stb.wrLane = byteEn;
        W_24: stb.wrLane = {1'b0, byteEn[LANES-2:0]};
        W_16: begin
          stb.wrLane  = {2'b00, byteEn[LANES/2-1:0]};
          stb.clrHigh = 1'b1;
        end
        default: stb.wrLane = '0;
      endcase
    end
  end
endmodule

// File: rtl/hctlDatapath.sv
module hctlDatapath
  import hctlPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlOut
);
  logic [DATA_W-1:0] shadowReg, activeReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowReg <= '0;
      activeReg <= '0;
    end else begin
      if (stb.commit) activeReg <= shadowReg & WR_MASK;
      for (int i = 0; i < LANES; i++) begin
        if (stb.wrLane[i])
          shadowReg[8*i +: 8] <= wrData[8*i +: 8];
        else if (stb.clrHigh && (i >= LANES/2))
          shadowReg[8*i +: 8] <= '0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn && stb.hit) begin
      unique case (stb.width)
        W_32:    rdData = activeReg;
        W_24:    rdData = {8'h00, activeReg[23:0]};
        W_16:    rdData = {16'h0000, activeReg[15:0]};
        default: rdData = '0;
      endcase
    end
  end

  assign ctrlOut = activeReg;
endmodule

// File: rtl/hostCtrlReg.sv
module hostCtrlReg
  import hctlPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UB_BASE_W  = 8,
  parameter int PCI_OFFSET = 'h010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           busMode,
  input  logic                 memSpace,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    pciBase,
  input  logic [UB_BASE_W-1:0] ubBase,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [3:0]           byteEn,
  input  logic [31:0]          wrData,
  input  logic                 commit,
  output logic [31:0]          rdData,
  output logic [31:0]          ctrlOut
);
  strobes_t stb;

  hctlControl #(.ADDR_W(ADDR_W), .UB_BASE_W(UB_BASE_W), .PCI_OFFSET(PCI_OFFSET)) u_ctl (
    .busMode (busMode),
    .memSpace(memSpace),
    .addr    (addr),
    .pciBase (pciBase),
    .ubBase  (ubBase),
    .wrEn    (wrEn),
    .byteEn  (byteEn),
    .commit  (commit),
    .txFmt   (ctrlOut[TXFMT_LSB +: 2]),
    .rxFmt   (ctrlOut[RXFMT_LSB +: 2]),
    .stb     (stb)
  );

  hctlDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdEn   (rdEn),
    .wrData (wrData),
    .rdData (rdData),
    .ctrlOut(ctrlOut)
  );
endmodule

// File: rtl/hctlChecker.sv
module hctlChecker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  busMode,
  input logic        commit,
  input logic [31:0] rdData,
  input logic [31:0] ctrlOut
);
  localparam logic [31:0] MASK = 32'h0104_7F3F;

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlOut & ~MASK) == 32'h0) && ((rdData & ~MASK) == 32'h0));

  a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(ctrlOut));

  a_r10_blocked_read: assert property (@(posedge clk) disable iff (!rstN)
    (busMode == 2'd0) |-> (rdData == 32'h0));

  a_r5_ub_top_byte_zero: assert property (@(posedge clk) disable iff (!rstN)
    busMode[1] |-> (rdData[31:24] == 8'h00));

  a_r6_narrow_read: assert property (@(posedge clk) disable iff (!rstN)
    (busMode[1] && (ctrlOut[9:8] != 2'd0) && (ctrlOut[11:10] != 2'd0))
      |-> (rdData[31:16] == 16'h0000));
endmodule

bind hostCtrlReg hctlChecker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busMode(busMode),
  .commit (commit),
  .rdData (rdData),
  .ctrlOut(ctrlOut)
);

// File: tb/hostCtrlReg_bench.sv
module hostCtrlReg_bench;
  localparam logic [31:0] MASK   = 32'h0104_7F3F;
  localparam logic [31:0] PBASE  = 32'h4000_0000;
  localparam logic [7:0]  UBASE  = 8'h5A;
  localparam logic [31:0] PADDR  = PBASE + 32'h10;
  localparam logic [31:0] UADDR  = {21'd0, UBASE, 3'd4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busMode = '0;
  logic memSpace = 1'b0;
  logic [31:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, commit = 1'b0;
  logic [3:0] byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, ctrlOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] mShadow = '0;
  logic [31:0] mActive = '0;

  always #4 clk = ~clk;

  hostCtrlReg u_hostCtrlReg (
    .clk(clk), .rstN(rstN), .busMode(busMode), .memSpace(memSpace),
    .addr(addr), .pciBase(PBASE), .ubBase(UBASE), .wrEn(wrEn), .rdEn(rdEn),
    .byteEn(byteEn), .wrData(wrData), .commit(commit),
    .rdData(rdData), .ctrlOut(ctrlOut)
  );

  // model: 0 none, 16, 24, 32
  function automatic int accWidth();
    if (busMode == 2'd1 && memSpace && addr == PADDR) return 32;
    if (busMode[1] && addr[10:3] == UBASE && addr[2:0] == 3'd4)
      return (mActive[9:8] != 0 && mActive[11:10] != 0) ? 16 : 24;
    return 0;
  endfunction

  task automatic compare(string tag);
    int w;
    logic [31:0] expRd;
    w = accWidth();
    expRd = 32'h0;
    if (rdEn) begin
      if (w == 32) expRd = mActive;
      else if (w == 24) expRd = mActive & 32'h00FF_FFFF;
      else if (w == 16) expRd = mActive & 32'h0000_FFFF;
    end
    checks++;
    if (rdData !== expRd) begin
      errors++;
      $display("FAIL %s rdData actual %h expected %h", tag, rdData, expRd);
    end
    checks++;
    if (ctrlOut !== mActive) begin
      errors++;
      $display("FAIL %s ctrlOut actual %h expected %h", tag, ctrlOut, mActive);
    end
  endtask

  task automatic modelEdge();
    int w;
    logic [31:0] oldShadow;
    w = accWidth();
    oldShadow = mShadow;
    if (!rstN) begin
      mShadow = '0; mActive = '0;
    end else begin
      if (commit) mActive = oldShadow & MASK;
      if (wrEn && w != 0) begin
        for (int i = 0; i < 4; i++) begin
          if (byteEn[i] && (w == 32 || (w == 24 && i < 3) || (w == 16 && i < 2)))
            mShadow[8*i +: 8] = wrData[8*i +: 8];
          else if (w == 16 && i >= 2)
            mShadow[8*i +: 8] = 8'h00;
        end
      end
    end
  endtask

  task automatic step(string tag, logic [1:0] m, logic ms, logic [31:0] a,
                      logic we, logic re, logic [3:0] be, logic [31:0] d, logic cm);
    busMode = m; memSpace = ms; addr = a; wrEn = we; rdEn = re;
    byteEn = be; wrData = d; commit = cm;
    #1;
    compare(tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 3; k++) idle("R1");
    rstN = 1'b1;
    idle("R1");

    // R8: write pending, read still old value before commit
    step("R3", 2'd1, 1'b1, PADDR, 1'b1, 1'b0, 4'hF, 32'hFFFF_FFFF, 1'b0);
    step("R8", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);
    idle("R8");
    step("R8", 2'd1, 1'b1, PADDR, 1'b0, 1'b0, 4'h0, 32'h0, 1'b1);
    // R3 + R9: full read, reserved bits zero
    step("R9", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R2: wrong address and non-memory space ignored
    step("R2", 2'd1, 1'b1, PADDR + 32'h4, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0);
    step("R2", 2'd1, 1'b0, PADDR, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
    step("R2", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R10: blocked mode
    step("R10", 2'd0, 1'b1, PADDR, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
    step("R10", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R7: partial lanes
    step("R7", 2'd1, 1'b1, PADDR, 1'b1, 1'b0, 4'b0101, 32'h0, 1'b0);
    step("R7", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b1);
    step("R7", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R6: both formats nonzero -> 16-bit, upper cleared
    step("R6", 2'd2, 1'b0, UADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);
    step("R6", 2'd2, 1'b0, UADDR, 1'b1, 1'b0, 4'hF, 32'hFFFF_0F3F, 1'b0);
    step("R6", 2'd2, 1'b0, UADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b1);
    step("R6", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R4: universal-bus decode misses
    step("R4", 2'd3, 1'b0, UADDR + 32'h1, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0);
    step("R4", 2'd3, 1'b0, UADDR ^ 32'h400, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
    step("R4", 2'd3, 1'b0, UADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R5: set upper option via PCI, then clear tx format -> 24-bit
    step("R5", 2'd1, 1'b1, PADDR, 1'b1, 1'b0, 4'hF, 32'h0104_0C3F, 1'b0);
    step("R5", 2'd1, 1'b1, PADDR, 1'b0, 1'b0, 4'h0, 32'h0, 1'b1);
    step("R5", 2'd3, 1'b0, UADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);
    step("R5", 2'd3, 1'b0, UADDR, 1'b1, 1'b0, 4'hF, 32'h00FF_FFFF, 1'b0);
    step("R5", 2'd3, 1'b0, UADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b1);
    step("R5", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b0);

    // R8: commit and write in the same cycle takes the older pending value
    step("R8", 2'd1, 1'b1, PADDR, 1'b1, 1'b0, 4'hF, 32'h0, 1'b1);
    step("R8", 2'd1, 1'b1, PADDR, 1'b0, 1'b1, 4'h0, 32'h0, 1'b1);

    // R7: mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      logic [31:0] a;
      logic [1:0] m;
      r = $urandom;
      m = r[1:0];
      case (r[4:3])
        2'd0: a = PADDR;
        2'd1: a = UADDR;
        2'd2: a = UADDR + {29'd0, r[7:5]};
        default: a = $urandom;
      endcase
      step("R7", m, r[8], a, r[9], r[10], r[14:11], $urandom, r[15] & r[16]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule